// File: doc/BRIEF.md
# PS/2 Mouse Command Error and Resend Controller

This block sits between the serial link receiver/transmitter and the command logic of a pointing-device controller. Every byte the host sends arrives with a parity-error and a framing-error flag. The block sorts each byte into one of three kinds: an ordinary command, a bad input, or a host request to repeat (0xFE). It then chooses the reply. A bad input gets a request for the host to repeat (0xFE), or the error code 0xFC once bad inputs come back to back. A host repeat request gets a replay of the most recent data packet. An ordinary command gets a one-cycle strobe that clears the movement accumulators.

Data packets of one to three bytes enter through a load port. The block sends them byte by byte over a transmit handshake and keeps a copy for later replays. The 0xFE and 0xFC replies are never kept as that copy. In stream mode, a replay of a full three-byte packet is followed by the accumulator-clear strobe. Decoding of individual commands is done elsewhere.

Top module: `ps2_mouse_err_ctrl`

## Requirements
- R1: After reset, tx_valid and cnt_clr are low and pkt_ready is high while rx_valid is low.
- R2: A byte accepted with rx_par_err or rx_frm_err set, when the previous accepted byte was good, causes the single reply byte 0xFE (tx_valid high from the cycle after acceptance).
- R3: A bad byte that directly follows another accepted bad byte causes the single reply 0xFC instead. The bad-input run count then returns to zero, so a third consecutive bad byte again gets 0xFE.
- R4: A good accepted byte other than 0xFE pulses cnt_clr high for exactly the one cycle after acceptance, transmits nothing, and resets the bad-input run count.
- R5: A good accepted 0xFE replays the stored packet in its original order and does not change the stored copy. Outside stream mode it raises no cnt_clr. It also resets the bad-input run count.
- R6: In stream mode, a 0xFE that replays a stored three-byte packet pulses cnt_clr in the cycle after the last replayed byte completes, and not earlier.
- R7: When pkt_valid and pkt_ready are both high, pkt_len (1 to 3) bytes are taken from pkt_data. Byte 0 is in bits [7:0] and is sent first. The block transmits them and stores them as the replay copy.
- R8: The 0xFE and 0xFC replies are never stored, so a replay after them repeats the earlier data packet.
- R9: tx_byte holds steady while tx_valid is high until tx_done is seen without tx_abort. A tx_abort keeps the same byte offered, so it is retried before the next one.
- R10: While a reply or packet is being sent, rx_valid and pkt_valid are ignored. pkt_ready is low whenever a transmission is in progress or rx_valid is high, so a host byte takes priority over a packet load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_mode | input | 1 | High when the device reports in stream mode |
| rx_valid | input | 1 | One-cycle strobe: a host byte was received |
| rx_byte | input | 8 | Received host byte |
| rx_par_err | input | 1 | Received byte failed its parity check |
| rx_frm_err | input | 1 | Received byte had a framing error |
| pkt_valid | input | 1 | A new data packet is offered |
| pkt_len | input | 2 | Packet length in bytes, 1 to 3 |
| pkt_data | input | 24 | Packet bytes, byte 0 in bits [7:0] |
| pkt_ready | output | 1 | Block can take a packet this cycle |
| tx_valid | output | 1 | A byte is offered to the link transmitter |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_done | input | 1 | Transmitter finished the offered byte |
| tx_abort | input | 1 | Host broke off the offered byte; retry it |
| cnt_clr | output | 1 | One-cycle clear of the movement accumulators |

## Verification
A wrong bad-input run count shows up as a swapped reply byte (0xFE where 0xFC belongs, or the reverse) one cycle after the second or third bad byte. A wrong replay index or a corrupted stored copy appears at tx_byte on the first replayed byte. A wrong stored length shows as extra or missing bytes before tx_valid falls. A misplaced clear shows as cnt_clr one cycle early, late or absent, checked against the exact edge after acceptance or after the final transmit completion.

// File: rtl/ps2ec_pkg.sv
package ps2ec_pkg;
  localparam logic [7:0] CODE_RESEND = 8'hFE;
  localparam logic [7:0] CODE_ERROR  = 8'hFC;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_CMD,
    EV_RESEND,
    EV_BAD,
    EV_BAD_LIMIT
  } rx_ev_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CODE,
    ST_DATA
  } tx_st_e;
endpackage

// File: rtl/ps2ec_rx_class.sv
module ps2ec_rx_class
  import ps2ec_pkg::*;
#(
  parameter int W         = 8,
  parameter int ERR_LIMIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic [W-1:0] rx_byte,
  input  logic         rx_par_err,
  input  logic         rx_frm_err,
  output rx_ev_e       ev
);
  localparam int CW = $clog2(ERR_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(ERR_LIMIT - 1);

  logic [CW-1:0] run_q, run_d;
  logic          bad;

  assign bad = rx_par_err | rx_frm_err;

  always_comb begin
    ev    = EV_NONE;
    run_d = run_q;
    if (accept) begin
      if (bad) begin
        if (run_q == LAST) begin
          ev    = EV_BAD_LIMIT;
          run_d = '0;
        end else begin
          ev    = EV_BAD;
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
        ev    = (rx_byte == W'(CODE_RESEND)) ? EV_RESEND : EV_CMD;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (accept) run_q <= run_d;
  end
endmodule

// File: rtl/ps2ec_pktbuf.sv
module ps2ec_pktbuf #(
  parameter int W    = 8,
  parameter int MAXB = 3,
  localparam int LW  = $clog2(MAXB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [LW-1:0]     load_len,
  input  logic [MAXB*W-1:0] load_data,
  input  logic [LW-1:0]     rd_idx,
  output logic [LW-1:0]     len_q,
  output logic [W-1:0]      rd_byte
);
  logic [W-1:0] slot_q [MAXB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= '0;
    else if (load) len_q <= load_len;
  end

  for (genvar g = 0; g < MAXB; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    slot_q[g] <= '0;
      else if (load) slot_q[g] <= load_data[g*W +: W];
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < MAXB; i++)
      if (rd_idx == LW'(i)) rd_byte = slot_q[i];
  end
endmodule

// File: rtl/ps2_mouse_err_ctrl.sv
module ps2_mouse_err_ctrl
  import ps2ec_pkg::*;
#(
  parameter int W         = 8,
  parameter int MAXB      = 3,
  parameter int ERR_LIMIT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stream_mode,
  input  logic                      rx_valid,
  input  logic [W-1:0]              rx_byte,
  input  logic                      rx_par_err,
  input  logic                      rx_frm_err,
  input  logic                      pkt_valid,
  input  logic [$clog2(MAXB+1)-1:0] pkt_len,
  input  logic [MAXB*W-1:0]         pkt_data,
  output logic                      pkt_ready,
  output logic                      tx_valid,
  output logic [W-1:0]              tx_byte,
  input  logic                      tx_done,
  input  logic                      tx_abort,
  output logic                      cnt_clr
);
  localparam int LW = $clog2(MAXB + 1);
  localparam logic [LW-1:0] FULL = LW'(MAXB);

  tx_st_e        st_q, st_d;
  logic [LW-1:0] idx_q, idx_d;
  logic [W-1:0]  code_q, code_d;
  logic          clr_after_q, clr_after_d;
  logic          cnt_clr_q, cnt_clr_d;
  logic          idle, accept, pkt_go, advance;
  logic [LW-1:0] len_q;
  logic [W-1:0]  rd_byte;
  rx_ev_e        ev;

  assign idle      = (st_q == ST_IDLE);
  assign accept    = idle & rx_valid;
  assign pkt_ready = idle & ~rx_valid;
  assign pkt_go    = pkt_valid & pkt_ready & (pkt_len != '0);
  assign advance   = tx_done & ~tx_abort;

  ps2ec_rx_class #(.W(W), .ERR_LIMIT(ERR_LIMIT)) u_class (
    .clk(clk), .rst_n(rst_n), .accept(accept), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .ev(ev)
  );

  ps2ec_pktbuf #(.W(W), .MAXB(MAXB)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(pkt_go), .load_len(pkt_len),
    .load_data(pkt_data), .rd_idx(idx_q), .len_q(len_q), .rd_byte(rd_byte)
  );

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    code_d      = code_q;
    clr_after_d = clr_after_q;
    cnt_clr_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        unique case (ev)
          EV_CMD:       cnt_clr_d = 1'b1;
          EV_BAD: begin
            code_d = W'(CODE_RESEND);
            st_d   = ST_CODE;
          end
          EV_BAD_LIMIT: begin
            code_d = W'(CODE_ERROR);
            st_d   = ST_CODE;
          end
          EV_RESEND: begin
            if (len_q != '0) begin
              st_d        = ST_DATA;
              idx_d       = '0;
              clr_after_d = stream_mode & (len_q == FULL);
            end
          end
          default: begin
            if (pkt_go) begin
              st_d        = ST_DATA;
              idx_d       = '0;
              clr_after_d = 1'b0;
            end
          end
        endcase
      end
      ST_CODE: if (advance) st_d = ST_IDLE;
      ST_DATA: begin
        if (advance) begin
          if (idx_q == len_q - 1'b1) begin
            st_d      = ST_IDLE;
            cnt_clr_d = clr_after_q;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      code_q      <= '0;
      clr_after_q <= 1'b0;
      cnt_clr_q   <= 1'b0;
    end else begin
      st_q        <= st_d;
      idx_q       <= idx_d;
      code_q      <= code_d;
      clr_after_q <= clr_after_d;
      cnt_clr_q   <= cnt_clr_d;
    end
  end

  assign tx_valid = ~idle;
  assign tx_byte  = (st_q == ST_CODE) ? code_q : rd_byte;
  assign cnt_clr  = cnt_clr_q;
endmodule

// File: rtl/ps2ec_checker.sv
module ps2ec_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rx_valid,
  input logic [W-1:0] rx_byte,
  input logic         rx_par_err,
  input logic         rx_frm_err,
  input logic         pkt_ready,
  input logic         tx_valid,
  input logic [W-1:0] tx_byte,
  input logic         tx_done,
  input logic         tx_abort,
  input logic         cnt_clr
);
  logic good_cmd, bad_in;
  assign bad_in   = rx_valid & ~tx_valid & (rx_par_err | rx_frm_err);
  assign good_cmd = rx_valid & ~tx_valid & ~rx_par_err & ~rx_frm_err &
                    (rx_byte != W'(8'hFE));

  assert_bad_reply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_in |=> tx_valid && (tx_byte == W'(8'hFE) || tx_byte == W'(8'hFC)));

  assert_cmd_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    good_cmd |=> cnt_clr && !tx_valid);

  assert_byte_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !(tx_done && !tx_abort)) |=> tx_valid && $stable(tx_byte));

  assert_no_clr_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_clr && tx_valid));

  assert_ready_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> !tx_valid && !rx_valid);
endmodule

bind ps2_mouse_err_ctrl ps2ec_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
  .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .pkt_ready(pkt_ready),
  .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_done(tx_done),
  .tx_abort(tx_abort), .cnt_clr(cnt_clr)
);

// File: tb/tb_ps2_mouse_err_ctrl.sv
module tb_ps2_mouse_err_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stream_mode = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_par_err = 1'b0;
  logic        rx_frm_err = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [1:0]  pkt_len = '0;
  logic [23:0] pkt_data = '0;
  logic        pkt_ready, tx_valid, cnt_clr;
  logic [7:0]  tx_byte;
  logic        tx_done = 1'b0;
  logic        tx_abort = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int clr_cnt = 0;
  bit finished = 0;
  logic [7:0] got [0:3];

  always #4 clk = ~clk;

  ps2_mouse_err_ctrl dut (
    .clk(clk), .rst_n(rst_n), .stream_mode(stream_mode), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
    .pkt_valid(pkt_valid), .pkt_len(pkt_len), .pkt_data(pkt_data),
    .pkt_ready(pkt_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_done(tx_done), .tx_abort(tx_abort), .cnt_clr(cnt_clr)
  );

  always @(negedge clk) if (cnt_clr) clr_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input bit par, input bit frm);
    rx_valid = 1'b1; rx_byte = b; rx_par_err = par; rx_frm_err = frm;
    @(negedge clk);
    rx_valid = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
  endtask

  task automatic load_pkt(input logic [1:0] len, input logic [23:0] d);
    pkt_valid = 1'b1; pkt_len = len; pkt_data = d;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  // serve n bytes from the transmitter side; abort once at index abort_at
  task automatic serve(input int n, input int abort_at, input string req);
    for (int i = 0; i < n; i++) begin
      int w = 0;
      while (!tx_valid && w < 20) begin @(negedge clk); w++; end
      chk(tx_valid, req, tx_valid, 1);
      got[i] = tx_byte;
      if (i == abort_at) begin
        tx_abort = 1'b1; @(negedge clk); tx_abort = 1'b0;
        chk(tx_valid && tx_byte == got[i], "R9", tx_byte, got[i]);
      end
      tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    end
  endtask

  task automatic expect_quiet(input string req);
    repeat (3) @(negedge clk);
    chk(!tx_valid, req, tx_valid, 0);
  endtask

  task automatic t_reset;
    chk(!tx_valid, "R1", tx_valid, 0);
    chk(!cnt_clr, "R1", cnt_clr, 0);
    chk(pkt_ready, "R1", pkt_ready, 1);
  endtask

  task automatic t_packet;
    load_pkt(2'd3, 24'h332211);
    chk(!pkt_ready, "R10", pkt_ready, 0);
    serve(3, -1, "R7");
    chk(got[0] == 8'h11 && got[1] == 8'h22 && got[2] == 8'h33, "R7",
        {got[0], got[1], got[2]}, 24'h112233);
    expect_quiet("R7");
  endtask

  task automatic t_command;
    int c0 = clr_cnt;
    send_rx(8'hF4, 0, 0);
    chk(cnt_clr, "R4", cnt_clr, 1);
    @(negedge clk);
    chk(!cnt_clr && clr_cnt == c0 + 1, "R4", clr_cnt - c0, 1);
    chk(!tx_valid, "R4", tx_valid, 0);
  endtask

  task automatic t_errors;
    int c0 = clr_cnt;
    send_rx(8'h12, 1, 0); serve(1, -1, "R2");
    chk(got[0] == 8'hFE, "R2", got[0], 8'hFE);
    send_rx(8'h34, 0, 1); serve(1, -1, "R3");
    chk(got[0] == 8'hFC, "R3", got[0], 8'hFC);
    send_rx(8'h56, 1, 0); serve(1, -1, "R3");
    chk(got[0] == 8'hFE, "R3", got[0], 8'hFE);
    send_rx(8'hE6, 0, 0); @(negedge clk);
    send_rx(8'h56, 1, 1); serve(1, -1, "R4");
    chk(got[0] == 8'hFE, "R4", got[0], 8'hFE);
    chk(clr_cnt == c0 + 1, "R4", clr_cnt - c0, 1);
    send_rx(8'hE8, 0, 0); @(negedge clk);
  endtask

  task automatic t_replay;
    int c0 = clr_cnt;
    stream_mode = 1'b0;
    send_rx(8'hFE, 0, 0); serve(3, -1, "R5");
    chk(got[0] == 8'h11 && got[1] == 8'h22 && got[2] == 8'h33, "R8",
        {got[0], got[1], got[2]}, 24'h112233);
    expect_quiet("R5");
    chk(clr_cnt == c0, "R5", clr_cnt - c0, 0);
  endtask

  task automatic t_stream;
    int c0 = clr_cnt;
    stream_mode = 1'b1;
    send_rx(8'hFE, 0, 0);
    serve(2, -1, "R6");
    chk(clr_cnt == c0, "R6", clr_cnt - c0, 0);
    serve(1, -1, "R6");
    chk(cnt_clr && got[0] == 8'h33, "R6", cnt_clr, 1);
    expect_quiet("R6");
    chk(clr_cnt == c0 + 1, "R6", clr_cnt - c0, 1);
    stream_mode = 1'b0;
  endtask

  task automatic t_abort;
    send_rx(8'hFE, 0, 0); serve(3, 1, "R9");
    chk(got[1] == 8'h22 && got[2] == 8'h33, "R9", {got[1], got[2]}, 16'h2233);
    expect_quiet("R9");
  endtask

  task automatic t_short_and_busy;
    int c0;
    load_pkt(2'd1, 24'h00005A); serve(1, -1, "R7");
    chk(got[0] == 8'h5A, "R7", got[0], 8'h5A);
    send_rx(8'h01, 1, 0); serve(1, -1, "R8");
    send_rx(8'hFE, 0, 0); serve(1, -1, "R8");
    chk(got[0] == 8'h5A, "R8", got[0], 8'h5A);
    expect_quiet("R8");
    c0 = clr_cnt;
    stream_mode = 1'b1;
    send_rx(8'hFE, 0, 0);
    chk(tx_valid && tx_byte == 8'h5A, "R5", tx_byte, 8'h5A);
    send_rx(8'hF4, 0, 0);
    send_rx(8'h99, 1, 0);
    load_pkt(2'd2, 24'h00BBAA);
    serve(1, -1, "R10");
    chk(got[0] == 8'h5A, "R10", got[0], 8'h5A);
    expect_quiet("R10");
    chk(clr_cnt == c0, "R10", clr_cnt - c0, 0);
    stream_mode = 1'b0;
    send_rx(8'hFE, 0, 0); serve(1, -1, "R10");
    chk(got[0] == 8'h5A, "R10", got[0], 8'h5A);
    expect_quiet("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_packet();
    t_command();
    t_errors();
    t_replay();
    t_stream();
    t_abort();
    t_short_and_busy();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule